// File: doc/BRIEF.md
# Bus Master Latency Timer

This block bounds how long a master may stretch one burst on a shared parallel bus after the arbiter has handed the bus to another agent. Software programs a tenure length into an 8-bit register. Only the upper five bits are stored, and they count in steps of eight bus clocks. A down-counter loads that length on the clock where the master begins driving its frame signal. It then counts one per clock while frame stays asserted, and it stops at zero.

Once the counter has run out, the block watches the arbiter grant. While the grant is still held, the master keeps the bus and no request is made. If the grant is gone, or goes away later during the same burst, the block raises a terminate request on the next clock. The master answers that request by deasserting frame. The request then stays high until frame is seen low. Arbitration itself, data movement and address decode belong to other blocks.

Top module: `bus_latency_timer`

## Requirements
- R1: A synchronous active-high reset clears the register to 00h and the terminate request to 0. The first read after reset returns 00h.
- R2: A write stores `wr_data_i[7:3]` as the count field. From the next clock on, the read port returns it in bits 7:3.
- R3: Bits 2:0 of a write are discarded, and bits 2:0 of the read port are always 0.
- R4: The tenure length L is the count field times 8. It is taken from the register value held on the clock where frame is first sampled high after being low. A write made during a burst does not change that burst's L.
- R5: Suppose frame rises at clock edge k and grant is low from then on. With L > 0, `term_o` goes high after edge k+L+1 and stays low before that.
- R6: While the grant stays high, `term_o` does not rise, even after the count has run out.
- R7: The counter does not wrap at zero. If the grant drops at any point after expiry during the same burst, `term_o` rises on the next clock edge.
- R8: Once raised, `term_o` stays high while frame stays high, even if the grant returns. It clears on the edge where frame is sampled low.
- R9: With a count field of 0, the timer has expired from the frame-start edge. If the grant is low at that edge, `term_o` is already high after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_i | input | 1 | Master is driving frame (active high) |
| gnt_i | input | 1 | Arbiter grant to this master (active high) |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read data |
| term_o | output | 1 | Request to end the burst by deasserting frame |

## Verification
The hardest case to reach is a grant that is withdrawn well after the count has run out, inside a burst that was allowed to continue. The terminate request must then rise one clock later, and it must stay high if the grant comes back before frame falls. Directed sequences hold frame high past expiry with grant high, then drop grant and restore it a few clocks later. Random bursts use small count fields so that expiry happens often, and each burst keeps frame high for a random length. Grant toggles at random inside the burst, and writes land in the middle of bursts.

// File: rtl/lt_pkg.sv
package lt_pkg;
    localparam int unsigned FIELD_W_DEF   = 5;
    localparam int unsigned STEP_LOG2_DEF = 3;

    // Tenure length in clocks: count field scaled by 2**step_log2.
    function automatic logic [15:0] tenure_len(input logic [15:0] field, input int unsigned step_log2);
        return field << step_log2;
    endfunction
endpackage

// File: rtl/lt_reg.sv
module lt_reg #(
    parameter int unsigned FIELD_W   = lt_pkg::FIELD_W_DEF,
    parameter int unsigned STEP_LOG2 = lt_pkg::STEP_LOG2_DEF,
    localparam int unsigned REG_W    = FIELD_W + STEP_LOG2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en_i,
    input  logic [REG_W-1:0]   wr_data_i,
    output logic [FIELD_W-1:0] field_o,
    output logic [REG_W-1:0]   rd_data_o
);
    typedef struct packed {
        logic [FIELD_W-1:0] field;
    } reg_s;

    reg_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            st_d.field = wr_data_i[REG_W-1:STEP_LOG2];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign field_o   = st_q.field;
    assign rd_data_o = {st_q.field, {STEP_LOG2{1'b0}}};

    p_field_holds_r2: assert property (@(posedge clk) disable iff (rst)
        !wr_en_i |=> $stable(st_q.field));
endmodule

// File: rtl/lt_tenure.sv
module lt_tenure #(
    parameter int unsigned FIELD_W   = lt_pkg::FIELD_W_DEF,
    parameter int unsigned STEP_LOG2 = lt_pkg::STEP_LOG2_DEF,
    localparam int unsigned CNT_W    = FIELD_W + STEP_LOG2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               frame_i,
    input  logic               gnt_i,
    input  logic [FIELD_W-1:0] field_i,
    output logic               term_o
);
    typedef struct packed {
        logic             frame;
        logic [CNT_W-1:0] cnt;
        logic             term;
    } ten_s;

    ten_s st_d, st_q;
    logic             start;
    logic [CNT_W-1:0] load;
    logic             expired;

    always_comb begin
        start   = frame_i && !st_q.frame;
        load    = CNT_W'(lt_pkg::tenure_len(16'(field_i), STEP_LOG2));
        expired = start ? (load == '0) : (st_q.cnt == '0);

        st_d       = st_q;
        st_d.frame = frame_i;
        if (start) begin
            st_d.cnt = load;
        end else if (frame_i && st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
        st_d.term = frame_i && (st_q.term || (expired && !gnt_i));
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign term_o = st_q.term;

    p_load_on_start_r4: assert property (@(posedge clk) disable iff (rst)
        start |=> st_q.cnt == $past(load));
    p_no_wrap_r7: assert property (@(posedge clk) disable iff (rst)
        (st_q.cnt == '0 && !start) |=> st_q.cnt == '0);
    p_no_term_with_gnt_r6: assert property (@(posedge clk) disable iff (rst)
        (!st_q.term && gnt_i) |=> !st_q.term);
    p_term_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (st_q.term && frame_i) |=> st_q.term);
    p_term_clear_r8: assert property (@(posedge clk) disable iff (rst)
        !frame_i |=> !st_q.term);
endmodule

// File: rtl/bus_latency_timer.sv
module bus_latency_timer #(
    parameter int unsigned FIELD_W   = lt_pkg::FIELD_W_DEF,
    parameter int unsigned STEP_LOG2 = lt_pkg::STEP_LOG2_DEF,
    localparam int unsigned REG_W    = FIELD_W + STEP_LOG2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_i,
    input  logic             gnt_i,
    input  logic             wr_en_i,
    input  logic [REG_W-1:0] wr_data_i,
    output logic [REG_W-1:0] rd_data_o,
    output logic             term_o
);
    logic [FIELD_W-1:0] field;

    lt_reg #(.FIELD_W(FIELD_W), .STEP_LOG2(STEP_LOG2)) u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .field_o   (field),
        .rd_data_o (rd_data_o)
    );

    lt_tenure #(.FIELD_W(FIELD_W), .STEP_LOG2(STEP_LOG2)) u_tenure (
        .clk     (clk),
        .rst     (rst),
        .frame_i (frame_i),
        .gnt_i   (gnt_i),
        .field_i (field),
        .term_o  (term_o)
    );

    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (rd_data_o == '0 && !term_o));
    p_write_readback_r2_r3: assert property (@(posedge clk) disable iff (rst)
        wr_en_i |=> rd_data_o == {$past(wr_data_i[REG_W-1:STEP_LOG2]), {STEP_LOG2{1'b0}}});
    p_term_needs_drop_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(term_o) |-> $past(!gnt_i && frame_i));
endmodule

// File: tb/tb_bus_latency_timer.sv
`timescale 1ns/1ps
module tb_bus_latency_timer;
    logic       clk = 0;
    logic       rst, frame_i, gnt_i, wr_en_i;
    logic [7:0] wr_data_i, rd_data_o;
    logic       term_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // Model state
    int  m_field, m_cnt;
    bit  m_term, m_fprev;

    always #10 clk = ~clk;

    bus_latency_timer dut (.*);

    function automatic int f_len(int field); return field * 8; endfunction
    function automatic bit f_expired(bit start, int field, int cnt);
        return start ? (f_len(field) == 0) : (cnt == 0);
    endfunction
    function automatic int f_next_cnt(bit start, bit f, int field, int cnt);
        if (start) return f_len(field);
        if (f && cnt != 0) return cnt - 1;
        return cnt;
    endfunction

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input bit f, input bit g, input bit we, input logic [7:0] wd, input string tag);
        bit start, texp;
        @(negedge clk);
        frame_i = f; gnt_i = g; wr_en_i = we; wr_data_i = wd;
        @(posedge clk); #1;
        start  = f && !m_fprev;
        texp   = f_expired(start, m_field, m_cnt);
        m_term = f && (m_term || (texp && !g));
        m_cnt  = f_next_cnt(start, f, m_field, m_cnt);
        m_fprev = f;
        if (we) m_field = wd[7:3];
        check({tag, " term"}, {7'b0, term_o}, {7'b0, m_term});
        check({tag, " rd"}, rd_data_o, 8'(m_field << 3));
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1; frame_i = 0; gnt_i = 0; wr_en_i = 0; wr_data_i = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 0;
        m_field = 0; m_cnt = 0; m_term = 0; m_fprev = 0;
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        do_reset();
        // R1: reset state
        check("R1 rd", rd_data_o, 8'h00);
        check("R1 term", {7'b0, term_o}, 8'h00);

        // R2/R3: write all ones, low bits dropped
        cyc(0, 1, 1, 8'hFF, "R3");
        check("R3 low bits", rd_data_o, 8'hF8);
        cyc(0, 1, 1, 8'h0F, "R2");
        check("R2 readback", rd_data_o, 8'h08);

        // R5: field=1 (L=8), grant low; term rises 9 edges after start
        cyc(0, 1, 1, 8'h08, "R5");
        for (int i = 0; i < 9; i++) begin
            cyc(1, 0, 0, 0, "R5");
            check("R5 early", {7'b0, term_o}, 8'h00);
        end
        cyc(1, 0, 0, 0, "R5");
        check("R5 rise", {7'b0, term_o}, 8'h01);
        // R8: grant returns, term held; frame low clears
        cyc(1, 1, 0, 0, "R8");
        check("R8 hold", {7'b0, term_o}, 8'h01);
        cyc(0, 1, 0, 0, "R8");
        check("R8 clear", {7'b0, term_o}, 8'h00);

        // R6/R7: grant held long past expiry, then drop
        for (int i = 0; i < 20; i++) cyc(1, 1, 0, 0, "R6");
        check("R6 no term", {7'b0, term_o}, 8'h00);
        cyc(1, 0, 0, 0, "R7");
        check("R7 rise", {7'b0, term_o}, 8'h01);
        cyc(0, 1, 0, 0, "R8");

        // R4: write mid-burst does not change this burst's length
        cyc(1, 1, 0, 0, "R4");
        cyc(1, 1, 1, 8'hF8, "R4");
        for (int i = 0; i < 8; i++) cyc(1, 1, 0, 0, "R4");
        cyc(1, 0, 0, 0, "R4");
        check("R4 old length", {7'b0, term_o}, 8'h01);
        cyc(0, 1, 0, 0, "R4");

        // R9: field zero, grant low at start edge
        cyc(0, 1, 1, 8'h07, "R9");
        cyc(1, 0, 0, 0, "R9");
        check("R9 immediate", {7'b0, term_o}, 8'h01);
        cyc(0, 1, 0, 0, "R9");

        // Random bursts: R5 R6 R7 R8 by model
        for (int b = 0; b < 400; b++) begin
            int len = 1 + ($urandom % 30);
            cyc(0, 1, ($urandom % 2) == 0, 8'($urandom % 32), "R4 rand");
            for (int i = 0; i < len; i++)
                cyc(1, ($urandom % 4) != 0, ($urandom % 8) == 0, 8'($urandom % 32), "R7 rand");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule